// File: doc/BRIEF.md
# CTS-Gated Serial Transmitter with Modem-Status Interrupt

This block sends bytes as 8N1 asynchronous serial characters and watches four active-low modem-control lines: clear-to-send, data-set-ready, carrier-detect and ring. Bytes come in on a valid/ready handshake. An oversampling tick enable paces the serializer, and each bit lasts `OVS` ticks. When hardware flow control is on, a new character may start only while clear-to-send is asserted. The go/no-go decision for a back-to-back character is fixed at the middle of the current stop bit, and a character that has already started always runs to its end.

All four modem lines pass through two-flop synchronizers. The block keeps sticky change flags for clear-to-send, data-set-ready and carrier-detect, and a flag for the trailing edge of ring. A one-cycle status-read strobe clears these flags. One interrupt output combines them under a master enable. While flow control is on, a clear-to-send change reaches the interrupt only if it has its own enable set.

Top module: `uart_cts_modem`

## Requirements
- R1: After reset, `txd` is 1, `mstat` is 0, `modem_irq` is 0, and with `flow_en` low `tx_ready` is 1.
- R2: A character is a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. Each bit lasts `OVS` ticks of `baud_tick`. When `tx_valid` and `tx_ready` are both high at a rising edge, the byte is taken and the start bit is driven from the next cycle.
- R3: With `flow_en` low, a character starts as soon as data is valid, and `cts_n` has no effect on the transmitter.
- R4: With `flow_en` high, a character starts only while the synchronized `cts_n` is 0. While `cts_n` is 1, `tx_ready` stays 0 and `txd` stays 1.
- R5: With `flow_en` high, `cts_n` is sampled at the middle tick of each stop bit. A release (1) sampled there holds back the next character. A release after that point lets one more character start right after the stop bit.
- R6: A character in progress is never cut short or altered by a change on `cts_n`. `tx_ready` is high only while `txd` is 1.
- R7: Any change of the synchronized `cts_n` sets `mstat[0]`, whatever the value of `flow_en`.
- R8: A change of `dsr_n` sets `mstat[1]`. A change of `dcd_n` sets `mstat[3]`. A rise of `ri_n` from 0 to 1 sets `mstat[2]`, and a fall of `ri_n` sets nothing.
- R9: The `mstat` flags hold until `stat_rd` is pulsed, which clears them all. A change detected in the same cycle as the read is kept.
- R10: While `msi_en` is 0, `modem_irq` is 0.
- R11: With `msi_en` high and `flow_en` low, `mstat[0]` raises `modem_irq`. With `flow_en` high, it raises `modem_irq` only if `cts_ie` is also 1.
- R12: With `msi_en` high, any of `mstat[1]`, `mstat[2]` or `mstat[3]` raises `modem_irq`, whatever `flow_en` and `cts_ie` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte accepted when high together with `tx_valid` |
| baud_tick | input | 1 | Oversampling tick enable, `OVS` ticks per bit |
| txd | output | 1 | Serial output, idles high |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| dcd_n | input | 1 | Carrier-detect, active low |
| ri_n | input | 1 | Ring indicator, active low |
| flow_en | input | 1 | Hardware CTS flow control enable |
| msi_en | input | 1 | Master modem-status interrupt enable |
| cts_ie | input | 1 | CTS-change interrupt enable, used while `flow_en` is high |
| stat_rd | input | 1 | Status-read strobe, clears the flags |
| mstat | output | 4 | Flags: [0] CTS changed, [1] DSR changed, [2] ring trailing edge, [3] DCD changed |
| modem_irq | output | 1 | Modem-status interrupt |

## Verification
The assertions check on every cycle that the interrupt stays low while masked, that a flag survives until a read, that set line flags raise the unmasked interrupt, that an accepted byte begins with a low start bit, and that the handshake opens only while the line is high. The directed scenarios are needed for the rest. These are the exact bit order of a frame, the mid-stop-bit cutoff on either side of the sampling point, and holding off while clear-to-send is released. They also cover the flow-control gating of the clear-to-send interrupt and a change that lands in the same cycle as a read.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_st_e;

    localparam int unsigned NLINES    = 4;
    // positions in the synchronized line vector
    localparam int unsigned LN_CTS    = 0;
    localparam int unsigned LN_DSR    = 1;
    localparam int unsigned LN_DCD    = 2;
    localparam int unsigned LN_RI     = 3;
    // positions in the status flag vector
    localparam int unsigned FLAG_DCTS = 0;
    localparam int unsigned FLAG_DDSR = 1;
    localparam int unsigned FLAG_TERI = 2;
    localparam int unsigned FLAG_DDCD = 3;
endpackage

// File: rtl/msync.sv
module msync #(
    parameter int unsigned W       = 4,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.s1 <= {W{RST_VAL}};
            sync_q.s2 <= {W{RST_VAL}};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.s2;
endmodule

// File: rtl/uart_txgate.sv
module uart_txgate
    import mstat_pkg::*;
#(
    parameter int unsigned DW  = 8,
    parameter int unsigned OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    input  logic          baud_tick,
    input  logic          cts_s,
    input  logic          flow_en,
    output logic          txd
);
    localparam int unsigned CW   = $clog2(OVS);
    localparam int unsigned BW   = (DW > 1) ? $clog2(DW) : 1;
    localparam int unsigned HALF = OVS / 2;

    typedef struct packed {
        tx_st_e        st;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bitn;
        logic [DW-1:0] shreg;
        logic          gate;
    } tx_t;

    tx_t tx_d, tx_q;
    logic last_tick, mid_tick, idle_ok, b2b_ok, take;

    always_comb begin
        tx_d      = tx_q;
        last_tick = baud_tick && (tx_q.cnt == CW'(OVS - 1));
        mid_tick  = baud_tick && (tx_q.cnt == CW'(HALF - 1));
        idle_ok   = (tx_q.st == TX_IDLE) && (!flow_en || !cts_s);
        b2b_ok    = (tx_q.st == TX_STOP) && last_tick && (!flow_en || tx_q.gate);
        tx_ready  = idle_ok || b2b_ok;
        take      = tx_ready && tx_valid;

        if (tx_q.st != TX_IDLE && baud_tick)
            tx_d.cnt = last_tick ? '0 : tx_q.cnt + 1'b1;

        unique case (tx_q.st)
            TX_IDLE: begin
                tx_d.cnt = '0;
                if (take) begin
                    tx_d.st    = TX_START;
                    tx_d.shreg = tx_data;
                end
            end
            TX_START: begin
                if (last_tick) begin
                    tx_d.st   = TX_DATA;
                    tx_d.bitn = '0;
                end
            end
            TX_DATA: begin
                if (last_tick) begin
                    tx_d.shreg = tx_q.shreg >> 1;
                    if (tx_q.bitn == BW'(DW - 1))
                        tx_d.st = TX_STOP;
                    else
                        tx_d.bitn = tx_q.bitn + 1'b1;
                end
            end
            TX_STOP: begin
                if (mid_tick)
                    tx_d.gate = !cts_s;
                if (last_tick) begin
                    if (take) begin
                        tx_d.st    = TX_START;
                        tx_d.shreg = tx_data;
                    end else begin
                        tx_d.st = TX_IDLE;
                    end
                end
            end
            default: tx_d.st = TX_IDLE;
        endcase

        unique case (tx_q.st)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = tx_q.shreg[0];
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q.st    <= TX_IDLE;
            tx_q.cnt   <= '0;
            tx_q.bitn  <= '0;
            tx_q.shreg <= '0;
            tx_q.gate  <= 1'b0;
        end else begin
            tx_q <= tx_d;
        end
    end
endmodule

// File: rtl/mstat_flags.sv
module mstat_flags
    import mstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lvl,
    input  logic              stat_rd,
    input  logic              flow_en,
    input  logic              msi_en,
    input  logic              cts_ie,
    output logic [NLINES-1:0] flags,
    output logic              irq
);
    typedef struct packed {
        logic [NLINES-1:0] prev;
        logic [NLINES-1:0] flg;
    } fl_t;

    fl_t fl_d, fl_q;
    logic [NLINES-1:0] evt;

    always_comb begin
        evt            = '0;
        evt[FLAG_DCTS] = lvl[LN_CTS] ^ fl_q.prev[LN_CTS];
        evt[FLAG_DDSR] = lvl[LN_DSR] ^ fl_q.prev[LN_DSR];
        evt[FLAG_DDCD] = lvl[LN_DCD] ^ fl_q.prev[LN_DCD];
        evt[FLAG_TERI] = lvl[LN_RI] & ~fl_q.prev[LN_RI];

        fl_d.prev = lvl;
        fl_d.flg  = (fl_q.flg & {NLINES{~stat_rd}}) | evt;

        flags = fl_q.flg;
        irq   = msi_en & ((fl_q.flg[FLAG_DCTS] & (~flow_en | cts_ie))
                          | fl_q.flg[FLAG_DDSR]
                          | fl_q.flg[FLAG_TERI]
                          | fl_q.flg[FLAG_DDCD]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q.prev <= '1;
            fl_q.flg  <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end
endmodule

// File: rtl/uart_cts_modem.sv
module uart_cts_modem
    import mstat_pkg::*;
#(
    parameter int unsigned DW  = 8,
    parameter int unsigned OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    input  logic          baud_tick,
    output logic          txd,
    input  logic          cts_n,
    input  logic          dsr_n,
    input  logic          dcd_n,
    input  logic          ri_n,
    input  logic          flow_en,
    input  logic          msi_en,
    input  logic          cts_ie,
    input  logic          stat_rd,
    output logic [3:0]    mstat,
    output logic          modem_irq
);
    logic [NLINES-1:0] raw_lines, lvl;

    always_comb begin
        raw_lines         = '1;
        raw_lines[LN_CTS] = cts_n;
        raw_lines[LN_DSR] = dsr_n;
        raw_lines[LN_DCD] = dcd_n;
        raw_lines[LN_RI]  = ri_n;
    end

    msync #(.W(NLINES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_lines),
        .sync_o  (lvl)
    );

    uart_txgate #(.DW(DW), .OVS(OVS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .baud_tick (baud_tick),
        .cts_s     (lvl[LN_CTS]),
        .flow_en   (flow_en),
        .txd       (txd)
    );

    mstat_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl),
        .stat_rd (stat_rd),
        .flow_en (flow_en),
        .msi_en  (msi_en),
        .cts_ie  (cts_ie),
        .flags   (mstat),
        .irq     (modem_irq)
    );
endmodule

// File: rtl/uart_cts_modem_chk.sv
module uart_cts_modem_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       txd,
    input logic       stat_rd,
    input logic       msi_en,
    input logic [3:0] mstat,
    input logic       modem_irq
);
    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en |-> !modem_irq);

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !txd);

    // R6
    ready_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    // R9
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((mstat & $past(mstat)) == $past(mstat)));

    // R12
    line_flag_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_en && (mstat[1] || mstat[2] || mstat[3])) |-> modem_irq);
endmodule

bind uart_cts_modem uart_cts_modem_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .txd       (txd),
    .stat_rd   (stat_rd),
    .msi_en    (msi_en),
    .mstat     (mstat),
    .modem_irq (modem_irq)
);

// File: tb/sim_uart_cts_modem.sv
`timescale 1ns/1ps
module sim_uart_cts_modem;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       baud_tick = 1'b1;
    logic       txd;
    logic       cts_n = 1'b1, dsr_n = 1'b1, dcd_n = 1'b1, ri_n = 1'b1;
    logic       flow_en = 1'b0, msi_en = 1'b0, cts_ie = 1'b0, stat_rd = 1'b0;
    logic [3:0] mstat;
    logic       modem_irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    uart_cts_modem u0 (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .baud_tick(baud_tick), .txd(txd),
        .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n), .ri_n(ri_n),
        .flow_en(flow_en), .msi_en(msi_en), .cts_ie(cts_ie),
        .stat_rd(stat_rd), .mstat(mstat), .modem_irq(modem_irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, req, act, exp);
    endtask

    // Called at the negedge just after the accepting edge; samples mid-bit.
    task automatic check_frame(input logic [7:0] b, input string req);
        repeat (8) @(posedge clk);
        @(negedge clk);
        expect_eq({req, " start"}, {31'd0, txd}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            repeat (16) @(posedge clk);
            @(negedge clk);
            expect_eq({req, " data"}, {31'd0, txd}, {31'd0, b[i]});
        end
        repeat (16) @(posedge clk);
        @(negedge clk);
        expect_eq({req, " stop"}, {31'd0, txd}, 32'd1);
    endtask

    task automatic send_and_check(input logic [7:0] b, input string req);
        @(negedge clk);
        tx_data  = b;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        check_frame(b, req);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        stat_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_eq("R1 txd", {31'd0, txd}, 32'd1);
        expect_eq("R1 ready", {31'd0, tx_ready}, 32'd1);
        expect_eq("R1 mstat", {28'd0, mstat}, 32'd0);
        expect_eq("R1 irq", {31'd0, modem_irq}, 32'd0);
    endtask

    task automatic t_no_flow();
        flow_en = 1'b0;
        cts_n   = 1'b1;
        send_and_check(8'hA5, "R2 R3 frame A5");
        send_and_check(8'h3C, "R3 frame 3C cts released");
    endtask

    task automatic t_flow_hold();
        flow_en = 1'b1;
        cts_n   = 1'b1;
        @(negedge clk);
        tx_data  = 8'h5A;
        tx_valid = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i % 10 == 0) begin
                expect_eq("R4 held txd", {31'd0, txd}, 32'd1);
                expect_eq("R4 held ready", {31'd0, tx_ready}, 32'd0);
            end
        end
        cts_n = 1'b0;
        send_and_check(8'h5A, "R4 released frame");
    endtask

    task automatic t_early_release();
        flow_en = 1'b1;
        cts_n   = 1'b0;
        settle();
        fork
            send_and_check(8'h96, "R6 frame through cts release");
            begin
                repeat (100) @(posedge clk);
                @(negedge clk);
                cts_n    = 1'b1;
                tx_data  = 8'h0F;
                tx_valid = 1'b1;
            end
        join
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i % 8 == 0) begin
                expect_eq("R5 early release holds", {31'd0, txd}, 32'd1);
                expect_eq("R5 early release ready", {31'd0, tx_ready}, 32'd0);
            end
        end
        cts_n = 1'b0;
        send_and_check(8'h0F, "R5 held byte after cts");
    endtask

    task automatic t_late_release();
        flow_en = 1'b1;
        cts_n   = 1'b0;
        settle();
        fork
            send_and_check(8'hC3, "R5 first frame");
            begin
                @(posedge clk);
                repeat (120) @(posedge clk);
                @(negedge clk);
                tx_data  = 8'h81;
                tx_valid = 1'b1;
                repeat (35) @(posedge clk);
                @(negedge clk);
                cts_n = 1'b1;
            end
        join
        repeat (8) @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        check_frame(8'h81, "R5 late release lets one more");
        repeat (20) @(posedge clk);
        @(negedge clk);
        expect_eq("R5 idle after extra char", {31'd0, txd}, 32'd1);
        cts_n = 1'b0;
        settle();
    endtask

    task automatic t_cts_irq();
        flow_en = 1'b0;
        cts_ie  = 1'b0;
        msi_en  = 1'b0;
        clear_flags();
        cts_n = ~cts_n;
        settle();
        expect_eq("R7 dcts no flow", {28'd0, mstat}, 32'd1);
        expect_eq("R10 masked", {31'd0, modem_irq}, 32'd0);
        msi_en = 1'b1;
        @(negedge clk);
        expect_eq("R11 irq flow off", {31'd0, modem_irq}, 32'd1);
        clear_flags();
        expect_eq("R9 cleared", {28'd0, mstat}, 32'd0);
        flow_en = 1'b1;
        cts_n = ~cts_n;
        settle();
        expect_eq("R7 dcts flow on", {28'd0, mstat}, 32'd1);
        expect_eq("R11 no irq without cts_ie", {31'd0, modem_irq}, 32'd0);
        cts_ie = 1'b1;
        @(negedge clk);
        expect_eq("R11 irq with cts_ie", {31'd0, modem_irq}, 32'd1);
        clear_flags();
        expect_eq("R9 irq drops after read", {31'd0, modem_irq}, 32'd0);
        cts_ie = 1'b0;
    endtask

    task automatic t_line_irq();
        flow_en = 1'b1;
        cts_ie  = 1'b0;
        msi_en  = 1'b1;
        clear_flags();
        dsr_n = 1'b0;
        settle();
        expect_eq("R8 dsr flag", {28'd0, mstat}, 32'h2);
        expect_eq("R12 dsr irq", {31'd0, modem_irq}, 32'd1);
        clear_flags();
        ri_n = 1'b0;
        settle();
        expect_eq("R8 ri fall ignored", {28'd0, mstat}, 32'd0);
        expect_eq("R8 ri fall no irq", {31'd0, modem_irq}, 32'd0);
        ri_n = 1'b1;
        settle();
        expect_eq("R8 ri trailing edge", {28'd0, mstat}, 32'h4);
        expect_eq("R12 ri irq", {31'd0, modem_irq}, 32'd1);
        clear_flags();
        dcd_n = 1'b0;
        settle();
        expect_eq("R8 dcd flag", {28'd0, mstat}, 32'h8);
        expect_eq("R12 dcd irq", {31'd0, modem_irq}, 32'd1);
        msi_en = 1'b0;
        @(negedge clk);
        expect_eq("R10 masked line irq", {31'd0, modem_irq}, 32'd0);
        msi_en = 1'b1;
        clear_flags();
    endtask

    task automatic t_read_collision();
        msi_en = 1'b1;
        clear_flags();
        dsr_n = 1'b1;
        settle();
        expect_eq("R9 dsr set before read", {28'd0, mstat}, 32'h2);
        @(negedge clk);
        dcd_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        stat_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stat_rd = 1'b0;
        expect_eq("R9 same-cycle change kept", {28'd0, mstat}, 32'h8);
        expect_eq("R9 irq stays for new change", {31'd0, modem_irq}, 32'd1);
        clear_flags();
        expect_eq("R9 final clear", {28'd0, mstat}, 32'd0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_flow();
        t_flow_hold();
        t_early_release();
        t_late_release();
        t_cts_irq();
        t_line_irq();
        t_read_collision();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule